// File: doc/BRIEF.md
# Stop-Clock Grant State Controller

This block is the processor-side sequencer for an external stop-clock request. While the core runs, either executing or sitting in its halt power-down state, the system may pull an active-low stop request. The controller then asks the bus unit to issue a grant-acknowledge special cycle. It counts a fixed number of bus clocks from that cycle's response phase and then declares the stop-grant state. Releasing the request takes the controller back to whichever running state it left, normal or halt.

While stopped, the controller hands bus snoops to the snoop logic through a grant/done handshake and parks in a snoop sub-state until the snoop finishes. Sideband events (system-management interrupt, init, and the two local interrupt lines) that arrive while the core is not running are collapsed into one pending flag per source. These flags are offered to the interrupt logic once the core runs again. A core reset request raised while stopped produces an initialization pulse but does not end the stop. Bus electrical behaviour, the snoop itself and interrupt servicing stay outside; they are reached through handshake and flag ports.

Top module: `stop_clock_ctrl`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, state_o is 0 (RUN), and ack_cycle_req, stop_granted, snoop_grant, pend_valid, core_init and pend_flags are all 0.
- R2: In RUN (code 0) or HALT (code 1) with stpclk_req_n high, the next state is HALT when halted is 1 and RUN when it is 0.
- R3: In RUN or HALT, stpclk_req_n sampled low moves the state to ISSUE (code 2) and records the state it left. ack_cycle_req is 1 exactly while the state is ISSUE, and the state stays ISSUE until ack_resp is sampled high.
- R4: When ack_resp is sampled high in ISSUE with the request still low, the state becomes WAIT (code 3). stop_granted rises, with the state becoming STOP (code 4), at the ENTRY_DELAY-th rising edge (default 20) after the edge that sampled ack_resp.
- R5: stpclk_req_n sampled high in WAIT or STOP (with no snoop_req in STOP) returns the state to the recorded origin: HALT if the request was taken from HALT, otherwise RUN. A later request restarts the entry delay from zero.
- R6: If stpclk_req_n is high when ack_resp is sampled in ISSUE, the acknowledge cycle completes and the state returns directly to the recorded origin.
- R7: In STOP, snoop_req moves the state to SNOOP (code 5) and takes priority over a released request. snoop_grant is 1 exactly in SNOOP, and SNOOP returns to STOP on the edge that samples snoop_done.
- R8: A rising edge of cpu_reset gives a one-cycle pulse on core_init in the following cycle. cpu_reset never changes the state; in particular STOP is held.
- R9: An event on evt_in bit i (bit 0 SMI, bit 1 INIT, bit 2 LINT0, bit 3 LINT1) sampled while the state is not RUN or HALT sets pend_flags bit i. Any number of repeats leave a single set flag.
- R10: pend_valid is 1 only in RUN or HALT with at least one flag set. pend_ack sampled while pend_valid is 1 clears all flags at that edge. pend_ack at any other time has no effect.
- R11: In RUN or HALT, evt_out equals evt_in in the same cycle and the events are not latched. In all other states evt_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| stpclk_req_n | input | 1 | Active-low stop-clock request from the system |
| halted | input | 1 | Core is in its halt power-down state |
| ack_resp | input | 1 | Response phase of the grant-acknowledge cycle |
| snoop_req | input | 1 | A bus snoop is waiting to be serviced |
| snoop_done | input | 1 | Snoop logic has finished the current snoop |
| cpu_reset | input | 1 | Core reset request |
| evt_in | input | 4 | Sideband event pulses: SMI, INIT, LINT0, LINT1 |
| pend_ack | input | 1 | Consumer has taken the pending flags |
| state_o | output | 3 | Current state code |
| ack_cycle_req | output | 1 | Request to issue the grant-acknowledge cycle |
| stop_granted | output | 1 | Core is in the stop-grant state |
| snoop_grant | output | 1 | Snoop logic may run the snoop |
| core_init | output | 1 | One-cycle core initialization pulse |
| evt_out | output | 4 | Events passed straight through while running |
| pend_flags | output | 4 | Events held while the core was not running |
| pend_valid | output | 1 | Pending flags are being offered |

## Verification
The assertions assume that ack_resp and snoop_done are meaningful only while their matching request is up, and that the bus side may hold ack_resp off for any number of cycles. The checker therefore constrains only what the controller does with these inputs, never their timing. Random stimulus toggles the stop request rarely, so that the twenty-clock entry window completes often. It also holds back acknowledges and snoop completions for random stretches. Events, resets and consumer acknowledges fire at random in every state, including the illegal-looking ones such as pend_ack with nothing pending.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  localparam int EVT_N = 4;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_STOP  = 3'd4,
    ST_SNOOP = 3'd5
  } sgc_state_e;

  // state the controller goes back to when the stop request is dropped
  function automatic sgc_state_e home_state(input logic from_halt);
    return from_halt ? ST_HALT : ST_RUN;
  endfunction

  function automatic logic is_running(input sgc_state_e s);
    return (s == ST_RUN) || (s == ST_HALT);
  endfunction

  // merge new events into held flags; a clear wipes everything
  function automatic logic [EVT_N-1:0] merge_events(input logic [EVT_N-1:0] held,
                                                    input logic [EVT_N-1:0] evt,
                                                    input logic take,
                                                    input logic wipe);
    if (wipe) return '0;
    if (take) return held | evt;
    return held;
  endfunction

endpackage

// File: rtl/sgc_fsm.sv
module sgc_fsm
  import sgc_pkg::*;
#(
  parameter int ENTRY_DELAY = 20,
  localparam int CW = (ENTRY_DELAY > 1) ? $clog2(ENTRY_DELAY) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stpclk_req_n,
  input  logic          halted,
  input  logic          ack_resp,
  input  logic          snoop_req,
  input  logic          snoop_done,
  output sgc_state_e    state,
  output logic [CW-1:0] wait_cnt,
  output logic          delay_hit
);

  localparam logic [CW-1:0] LAST = CW'(ENTRY_DELAY - 1);

  sgc_state_e nxt;
  logic       from_halt;

  assign delay_hit = (wait_cnt == LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN, ST_HALT: begin
        if (!stpclk_req_n)      nxt = ST_ISSUE;
        else if (halted)        nxt = ST_HALT;
        else                    nxt = ST_RUN;
      end
      ST_ISSUE: begin
        if (ack_resp)           nxt = stpclk_req_n ? home_state(from_halt) : ST_WAIT;
      end
      ST_WAIT: begin
        if (stpclk_req_n)       nxt = home_state(from_halt);
        else if (delay_hit)     nxt = ST_STOP;
      end
      ST_STOP: begin
        if (snoop_req)          nxt = ST_SNOOP;
        else if (stpclk_req_n)  nxt = home_state(from_halt);
      end
      ST_SNOOP: begin
        if (snoop_done)         nxt = ST_STOP;
      end
      default:                  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      from_halt <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      state <= nxt;
      if (is_running(state) && !stpclk_req_n)
        from_halt <= (state == ST_HALT);
      if (state == ST_WAIT && nxt == ST_WAIT)
        wait_cnt <= wait_cnt + 1'b1;
      else
        wait_cnt <= '0;
    end
  end

endmodule

// File: rtl/sgc_evt_latch.sv
module sgc_evt_latch
  import sgc_pkg::*;
#(
  parameter int N = EVT_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic         capture,
  input  logic         wipe,
  output logic [N-1:0] pend
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= merge_events(N'(pend[i]) << i, N'(evt_in[i]) << i,
                                          capture, wipe) >> i;
    end
  end

endmodule

// File: rtl/sgc_init_pulse.sv
module sgc_init_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_reset,
  output logic core_init
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      core_init <= 1'b0;
    end else begin
      seen_q    <= cpu_reset;
      core_init <= cpu_reset & ~seen_q;
    end
  end

endmodule

// File: rtl/stop_clock_ctrl.sv
module stop_clock_ctrl
  import sgc_pkg::*;
#(
  parameter int ENTRY_DELAY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stpclk_req_n,
  input  logic             halted,
  input  logic             ack_resp,
  input  logic             snoop_req,
  input  logic             snoop_done,
  input  logic             cpu_reset,
  input  logic [EVT_N-1:0] evt_in,
  input  logic             pend_ack,
  output logic [2:0]       state_o,
  output logic             ack_cycle_req,
  output logic             stop_granted,
  output logic             snoop_grant,
  output logic             core_init,
  output logic [EVT_N-1:0] evt_out,
  output logic [EVT_N-1:0] pend_flags,
  output logic             pend_valid
);

  localparam int CW = (ENTRY_DELAY > 1) ? $clog2(ENTRY_DELAY) : 1;

  sgc_state_e    state;
  logic [CW-1:0] wait_cnt;
  logic          delay_hit;
  logic          running;
  logic          capture;
  logic          wipe;

  sgc_fsm #(.ENTRY_DELAY(ENTRY_DELAY)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stpclk_req_n (stpclk_req_n),
    .halted       (halted),
    .ack_resp     (ack_resp),
    .snoop_req    (snoop_req),
    .snoop_done   (snoop_done),
    .state        (state),
    .wait_cnt     (wait_cnt),
    .delay_hit    (delay_hit)
  );

  assign running = is_running(state);
  assign capture = ~running;
  assign wipe    = pend_valid & pend_ack;

  sgc_evt_latch #(.N(EVT_N)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_in  (evt_in),
    .capture (capture),
    .wipe    (wipe),
    .pend    (pend_flags)
  );

  sgc_init_pulse u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_reset (cpu_reset),
    .core_init (core_init)
  );

  assign state_o       = state;
  assign ack_cycle_req = (state == ST_ISSUE);
  assign stop_granted  = (state == ST_STOP);
  assign snoop_grant   = (state == ST_SNOOP);
  assign pend_valid    = running & (|pend_flags);
  assign evt_out       = running ? evt_in : '0;

endmodule

// File: rtl/stop_clock_ctrl_chk.sv
module stop_clock_ctrl_chk
  import sgc_pkg::*;
#(
  parameter int ENTRY_DELAY = 20,
  parameter int CW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stpclk_req_n,
  input logic             ack_resp,
  input logic             snoop_req,
  input logic             snoop_done,
  input logic [EVT_N-1:0] evt_in,
  input logic             pend_ack,
  input logic [2:0]       state_o,
  input logic             core_init,
  input logic [EVT_N-1:0] evt_out,
  input logic [EVT_N-1:0] pend_flags,
  input logic             pend_valid,
  input logic             running,
  input logic [CW-1:0]    wait_cnt
);

  localparam logic [CW-1:0] LAST = CW'(ENTRY_DELAY - 1);

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && !ack_resp) |=> state_o == 3'd2);

  // R4
  entry_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && $past(state_o) == 3'd3) |-> $past(wait_cnt) == LAST);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= LAST);

  // R7
  snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !snoop_done) |=> state_o == 3'd5);

  // R8
  stop_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !stpclk_req_n && !snoop_req) |=> state_o == 3'd4);

  // R8
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_init |=> !core_init);

  // R9
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && |evt_in) |=> (pend_flags & $past(evt_in)) == $past(evt_in));

  // R10
  valid_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> running);

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && pend_ack) |=> pend_flags == '0);

  // R11
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> evt_out == '0);

endmodule

bind stop_clock_ctrl stop_clock_ctrl_chk #(.ENTRY_DELAY(ENTRY_DELAY), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stpclk_req_n (stpclk_req_n),
  .ack_resp     (ack_resp),
  .snoop_req    (snoop_req),
  .snoop_done   (snoop_done),
  .evt_in       (evt_in),
  .pend_ack     (pend_ack),
  .state_o      (state_o),
  .core_init    (core_init),
  .evt_out      (evt_out),
  .pend_flags   (pend_flags),
  .pend_valid   (pend_valid),
  .running      (running),
  .wait_cnt     (wait_cnt)
);

// File: tb/stop_clock_ctrl_test.sv
module stop_clock_ctrl_test;

  localparam int CLK_PERIOD  = 10;
  localparam int ENTRY_DELAY = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stpclk_req_n = 1'b1, halted = 1'b0, ack_resp = 1'b0;
  logic       snoop_req = 1'b0, snoop_done = 1'b0, cpu_reset = 1'b0, pend_ack = 1'b0;
  logic [3:0] evt_in = 4'd0;
  logic [2:0] state_o;
  logic       ack_cycle_req, stop_granted, snoop_grant, core_init, pend_valid;
  logic [3:0] evt_out, pend_flags;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  // bench-side expectation
  int   m_st = 0, m_cnt = 0;
  bit   m_org = 0, m_rq = 0, m_init = 0;
  logic [3:0] m_pend = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_clock_ctrl #(.ENTRY_DELAY(ENTRY_DELAY)) uut (
    .clk(clk), .rst_n(rst_n), .stpclk_req_n(stpclk_req_n), .halted(halted),
    .ack_resp(ack_resp), .snoop_req(snoop_req), .snoop_done(snoop_done),
    .cpu_reset(cpu_reset), .evt_in(evt_in), .pend_ack(pend_ack),
    .state_o(state_o), .ack_cycle_req(ack_cycle_req), .stop_granted(stop_granted),
    .snoop_grant(snoop_grant), .core_init(core_init), .evt_out(evt_out),
    .pend_flags(pend_flags), .pend_valid(pend_valid)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit run_st(input int s);
    return s == 0 || s == 1;
  endfunction

  function automatic int home(input bit org);
    return org ? 1 : 0;
  endfunction

  // compare all outputs with expectation, then advance one clock
  task automatic step();
    int nst;
    #1;
    chk("R2 R3 R4 R5 R6 R7", "state", int'(state_o), m_st);
    chk("R3", "ack_cycle_req", int'(ack_cycle_req), int'(m_st == 2));
    chk("R4", "stop_granted", int'(stop_granted), int'(m_st == 4));
    chk("R7", "snoop_grant", int'(snoop_grant), int'(m_st == 5));
    chk("R8", "core_init", int'(core_init), int'(m_init));
    chk("R9", "pend_flags", int'(pend_flags), int'(m_pend));
    chk("R10", "pend_valid", int'(pend_valid), int'(run_st(m_st) && m_pend != 0));
    chk("R11", "evt_out", int'(evt_out), run_st(m_st) ? int'(evt_in) : 0);
    nst = m_st;
    case (m_st)
      0, 1: if (!stpclk_req_n) begin m_org = (m_st == 1); nst = 2; end
            else nst = halted ? 1 : 0;
      2:    if (ack_resp) nst = stpclk_req_n ? home(m_org) : 3;
      3:    if (stpclk_req_n) nst = home(m_org);
            else if (m_cnt == ENTRY_DELAY - 1) nst = 4;
      4:    if (snoop_req) nst = 5; else if (stpclk_req_n) nst = home(m_org);
      5:    if (snoop_done) nst = 4;
      default: nst = 0;
    endcase
    if (run_st(m_st)) begin
      if (pend_ack && m_pend != 0) m_pend = 4'd0;
    end else m_pend = m_pend | evt_in;
    m_cnt  = (m_st == 3 && nst == 3) ? m_cnt + 1 : 0;
    m_init = cpu_reset && !m_rq;
    m_rq   = cpu_reset;
    @(posedge clk);
    m_st = nst;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4817));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "state in reset", int'(state_o), 0);
    chk("R1", "outputs in reset",
        int'({ack_cycle_req, stop_granted, snoop_grant, pend_valid, core_init, pend_flags}), 0);
    rst_n = 1'b1;
    step(); step();

    // R3 / R4: entry timing
    stpclk_req_n = 1'b0; step();
    step();
    chk("R3", "ack held without response", int'(ack_cycle_req), 1);
    ack_resp = 1'b1; step(); ack_resp = 1'b0;
    n = 0;
    while (!stop_granted && n < 100) begin step(); n++; end
    chk("R4", "edges from response to stop", n, ENTRY_DELAY);

    // R8: reset request keeps stop
    cpu_reset = 1'b1; step();
    chk("R8", "core_init pulse", int'(core_init), 1);
    step(); cpu_reset = 1'b0;
    chk("R8", "core_init single", int'(core_init), 0);
    chk("R8", "still stopped", int'(state_o), 4);

    // R9: repeated SMI collapses
    evt_in = 4'b0001; step(); evt_in = 4'b0000; step();
    evt_in = 4'b0001; step(); evt_in = 4'b1000; step(); evt_in = 4'b0000;
    chk("R9", "collapsed flags", int'(pend_flags), 4'b1001);

    // R7: snoop sub-state
    snoop_req = 1'b1; stpclk_req_n = 1'b1; step(); snoop_req = 1'b0;
    chk("R7", "snoop wins over release", int'(snoop_grant), 1);
    stpclk_req_n = 1'b0; step(); step();
    snoop_done = 1'b1; step(); snoop_done = 1'b0;
    chk("R7", "back to stop", int'(state_o), 4);

    // R5 / R10: exit to normal and drain flags
    stpclk_req_n = 1'b1; step();
    chk("R5", "return to run", int'(state_o), 0);
    chk("R10", "flags offered", int'(pend_valid), 1);
    pend_ack = 1'b1; step(); pend_ack = 1'b0;
    chk("R10", "flags cleared", int'(pend_flags), 0);

    // R11: running events pass and are not held
    evt_in = 4'b0010; #1;
    chk("R11", "pass through", int'(evt_out), 4'b0010);
    step(); evt_in = 4'b0000;
    chk("R11", "not latched", int'(pend_flags), 0);

    // R6: release during acknowledge, origin halt
    halted = 1'b1; step();
    stpclk_req_n = 1'b0; step(); halted = 1'b0;
    stpclk_req_n = 1'b1; ack_resp = 1'b1; step(); ack_resp = 1'b0;
    chk("R6", "return to halt", int'(state_o), 1);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(39) == 0) stpclk_req_n = ~stpclk_req_n;
      if ($urandom_range(7) == 0)  halted = ~halted;
      ack_resp   = ($urandom_range(3) == 0);
      snoop_req  = ($urandom_range(9) == 0);
      snoop_done = ($urandom_range(2) == 0);
      cpu_reset  = ($urandom_range(9) == 0);
      pend_ack   = ($urandom_range(2) == 0);
      evt_in     = 4'(($urandom_range(15) == 0) ? $urandom_range(15) : 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule